// File: doc/BRIEF.md
# Multi-core routing interrupt controller

This block gathers a set of level-sensitive interrupt lines and steers each one to any combination of processor cores and CPU interrupt pins. Each line is first gated by a software enable mask. A routing entry per line then names the cores that should see it and the CPU pins it should raise. The block drives one parent output for every core/pin pair, so the default build of 4 cores by 4 pins has 16 outputs.

Software reaches the block through a simple register port. Each access carries an address, a direction and a size in bytes. Routing entries are byte registers. The masked status, the enable mask, the set and clear strobes for the enable mask, and one status word per core are word registers. Parent outputs and read data are registered, so they reflect the state one clock edge after the stimulus.

Parent output `core*4+pin` is raised from a cross product. The core must have at least one pending line of its own, and at least one pending line (possibly a different one) must select that pin. Two lines routed to different core/pin pairs can therefore raise the two mixed pairs as well.

Top module: `irq_router`

## Requirements
- R1: After reset the enable mask and every routing byte read as zero, and every parent output is low even if all interrupt lines are high.
- R2: A word read at offset 0x20 returns the interrupt line levels ANDed with the enable mask, sampled at the clock edge of the read.
- R3: A word write to 0x28 ORs the data into the enable mask, and a word write to 0x2C clears the mask bits that are set in the data. A word read at 0x24 returns the mask.
- R4: Offsets 0x00 to 0x1F each hold one 8-bit routing byte for the line of the same number. The byte is written and read only with 1-byte accesses. Bits 0 to 3 select cores 0 to 3, and bits 4 to 7 select CPU pins 0 to 3.
- R5: A word read at 0x40 + 8*c (c = 0..3) returns the masked status bits of the lines whose routing byte has core bit c set. A write to such an offset leaves no trace.
- R6: Parent output c*4+p is high exactly when core c's status word is nonzero and at least one masked-active line has pin bit p set. This holds even when the two conditions come from different lines.
- R7: Parent outputs follow line levels: they rise and fall at the first clock edge after a line or enable change. No interrupt is latched.
- R8: A word-window access (offset 0x20 and up, or any access that is not 1 byte) that is not exactly 4 bytes and 4-byte aligned has no effect and reads zero. This includes a 4-byte access into the routing area, and a 1-byte access at 0x20 or above.
- R9: Well-formed word reads of 0x28, 0x2C, unused offsets or offsets at 0x64 and above return zero. Word writes to 0x20, 0x24 and unused offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 3 | Access width in bytes (1 and 4 are meaningful) |
| bus_addr | input | 7 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data, a byte access uses bits 7:0 |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| parent_irq | output | 16 | Parent outputs, bit core*4+pin |

## Verification
A fixed routing table gives each line a distinct core/pin pair, with one line routed everywhere and one routed to pins but no core. A table of line patterns is then applied to it. The patterns are no line, a single line, a disabled line, two lines on different pairs, the pin-only line, all lines, and a checkerboard. Together they separate the cross-product rule from a per-line pairing, the enable mask from raw levels, and the core gate from the pin gate. Directed cases cover mask accumulation through set and clear, malformed sizes and alignments, writes to read-only and recomputed offsets, a line dropping, and a reset while lines are active.

// File: rtl/irq_router_pkg.sv
// Package: shared constants and the access-class type for the routing
// interrupt controller. Assumes a 7-bit byte-offset register window.
package irq_router_pkg;

    localparam int unsigned ADDR_W      = 7;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ROUTE_W     = 8;

    localparam int unsigned OFS_STATUS  = 'h20;
    localparam int unsigned OFS_ENABLE  = 'h24;
    localparam int unsigned OFS_EN_SET  = 'h28;
    localparam int unsigned OFS_EN_CLR  = 'h2C;
    localparam int unsigned OFS_CORE0   = 'h40;
    localparam int unsigned CORE_STRIDE = 8;
    localparam int unsigned WINDOW_END  = 'h64;

    localparam logic [2:0]  SIZE_BYTE   = 3'd1;
    localparam logic [2:0]  SIZE_WORD   = 3'd4;

    // Class of a register access after decode.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ROUTE,
        ACC_STATUS,
        ACC_ENABLE,
        ACC_EN_SET,
        ACC_EN_CLR,
        ACC_CORE
    } acc_kind_e;

endpackage

// File: rtl/irq_access_decode.sv
// Module: irq_access_decode
// Classifies an access by offset and size. Byte accesses below N_LINES
// reach the routing table. Aligned 4-byte accesses inside the window reach
// the word registers. Anything else is ACC_NONE.
// Assumes N_LINES <= 32 so the routing table ends below the word registers.
module irq_access_decode
    import irq_router_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_CORES = 4,
    localparam int unsigned LINE_IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int unsigned CORE_IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2:0]            size,
    output acc_kind_e             kind,
    output logic [LINE_IDX_W-1:0] line_idx,
    output logic [CORE_IDX_W-1:0] core_idx
);

    // Purpose: map offset and size to an access class and an index.
    always_comb begin
        kind     = ACC_NONE;
        core_idx = '0;
        line_idx = addr[LINE_IDX_W-1:0];
        if (size == SIZE_BYTE && int'(addr) < int'(N_LINES)) begin
            kind = ACC_ROUTE;
        end else if (size == SIZE_WORD && addr[1:0] == 2'b00 &&
                     int'(addr) < int'(WINDOW_END)) begin
            case (int'(addr))
                OFS_STATUS: kind = ACC_STATUS;
                OFS_ENABLE: kind = ACC_ENABLE;
                OFS_EN_SET: kind = ACC_EN_SET;
                OFS_EN_CLR: kind = ACC_EN_CLR;
                default:    kind = ACC_NONE;
            endcase
            for (int c = 0; c < int'(N_CORES); c++) begin
                if (int'(addr) == int'(OFS_CORE0) + c * int'(CORE_STRIDE)) begin
                    kind     = ACC_CORE;
                    core_idx = CORE_IDX_W'(c);
                end
            end
        end
    end

endmodule

// File: rtl/irq_regfile.sv
// Module: irq_regfile
// Holds the enable mask and the routing table, applies writes, and
// registers read data. Status words come in from the routing matrix and
// are only read here. Writes to them are dropped because they are
// recomputed every cycle.
// Assumes one access per strobe and N_CORES + N_PINS <= 8.
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_CORES = 4,
    parameter int unsigned N_PINS  = 4,
    localparam int unsigned RW         = N_CORES + N_PINS,
    localparam int unsigned LINE_IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int unsigned CORE_IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  acc_kind_e                  kind,
    input  logic [LINE_IDX_W-1:0]      line_idx,
    input  logic [CORE_IDX_W-1:0]      core_idx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [N_LINES-1:0]         masked,
    input  logic [N_CORES*N_LINES-1:0] core_status,
    output logic [N_LINES-1:0]         enable,
    output logic [N_LINES*RW-1:0]      route_flat,
    output logic [DATA_W-1:0]          rdata
);

    logic [N_LINES-1:0] enable_q;
    logic [RW-1:0]      route_q [N_LINES];
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rd_next;

    // Purpose: expose the routing table as one flat vector for the matrix.
    for (genvar i = 0; i < int'(N_LINES); i++) begin : g_flat
        assign route_flat[i*RW +: RW] = route_q[i];
    end

    // Purpose: select read data for the decoded register, zero otherwise.
    always_comb begin
        rd_next = '0;
        case (kind)
            ACC_ROUTE:  rd_next[RW-1:0]      = route_q[line_idx];
            ACC_STATUS: rd_next[N_LINES-1:0] = masked;
            ACC_ENABLE: rd_next[N_LINES-1:0] = enable_q;
            ACC_CORE:   rd_next[N_LINES-1:0] =
                            core_status[int'(core_idx)*N_LINES +: N_LINES];
            default:    rd_next = '0;
        endcase
    end

    // Purpose: apply writes to mask and routing table, capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            rdata_q  <= '0;
            for (int i = 0; i < int'(N_LINES); i++) begin
                route_q[i] <= '0;
            end
        end else begin
            if (acc_valid && acc_write) begin
                case (kind)
                    ACC_ROUTE:  route_q[line_idx] <= wdata[RW-1:0];
                    ACC_EN_SET: enable_q <= enable_q | wdata[N_LINES-1:0];
                    ACC_EN_CLR: enable_q <= enable_q & ~wdata[N_LINES-1:0];
                    default: ;
                endcase
            end
            if (acc_valid && !acc_write) begin
                rdata_q <= rd_next;
            end
        end
    end

    assign enable = enable_q;
    assign rdata  = rdata_q;

    // R3: every bit written through the set offset is present afterwards.
    a_r3_set_ors_in: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && kind == ACC_EN_SET)
        |=> ((enable_q & $past(wdata[N_LINES-1:0])) == $past(wdata[N_LINES-1:0])));

    // R3: every bit written through the clear offset is gone afterwards.
    a_r3_clr_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && kind == ACC_EN_CLR)
        |=> ((enable_q & $past(wdata[N_LINES-1:0])) == '0));

    // R8: a malformed or unmapped write leaves mask and table untouched.
    a_r8_bad_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && kind == ACC_NONE)
        |=> ($stable(enable_q) && $stable(route_flat)));

    // R9 and R5: writes to read-only or recomputed words change no state.
    a_r9_ro_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write &&
         (kind == ACC_STATUS || kind == ACC_ENABLE || kind == ACC_CORE))
        |=> ($stable(enable_q) && $stable(route_flat)));

endmodule

// File: rtl/irq_route_matrix.sv
// Module: irq_route_matrix
// Purely combinational. Masks the raw lines with the enable mask, then
// builds one status word per core and one pending flag per CPU pin from
// the routing bits. Assumes routing bits 0..N_CORES-1 are core selects and
// the next N_PINS bits are pin selects.
module irq_route_matrix #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_CORES = 4,
    parameter int unsigned N_PINS  = 4,
    localparam int unsigned RW = N_CORES + N_PINS
) (
    input  logic [N_LINES-1:0]         irq_in,
    input  logic [N_LINES-1:0]         enable,
    input  logic [N_LINES*RW-1:0]      route_flat,
    output logic [N_LINES-1:0]         masked,
    output logic [N_CORES*N_LINES-1:0] core_status,
    output logic [N_PINS-1:0]          pin_any
);

    // Purpose: level status gated by the enable mask.
    assign masked = irq_in & enable;

    // Purpose: per-core status words from the core-select bits.
    for (genvar c = 0; c < int'(N_CORES); c++) begin : g_core
        for (genvar i = 0; i < int'(N_LINES); i++) begin : g_line
            assign core_status[c*N_LINES + i] = masked[i] & route_flat[i*RW + c];
        end
    end

    // Purpose: per-pin pending flags from the pin-select bits.
    for (genvar p = 0; p < int'(N_PINS); p++) begin : g_pin
        logic [N_LINES-1:0] sel;
        for (genvar i = 0; i < int'(N_LINES); i++) begin : g_line
            assign sel[i] = route_flat[i*RW + N_CORES + p];
        end
        assign pin_any[p] = |(masked & sel);
    end

endmodule

// File: rtl/irq_parent_drive.sv
// Module: irq_parent_drive
// Registers the parent outputs. Output core*N_PINS+pin is the AND of
// "core has any pending line" and "pin has any pending line".
// Assumes the inputs are settled combinational results from the matrix.
module irq_parent_drive #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_CORES = 4,
    parameter int unsigned N_PINS  = 4,
    localparam int unsigned N_PARENTS = N_CORES * N_PINS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CORES*N_LINES-1:0] core_status,
    input  logic [N_PINS-1:0]          pin_any,
    output logic [N_PARENTS-1:0]       parent_irq
);

    logic [N_PARENTS-1:0] parent_d;
    logic [N_PARENTS-1:0] parent_q;

    // Purpose: cross product of core activity and pin activity.
    for (genvar c = 0; c < int'(N_CORES); c++) begin : g_core
        logic core_any;
        assign core_any = |core_status[c*N_LINES +: N_LINES];
        for (genvar p = 0; p < int'(N_PINS); p++) begin : g_pin
            assign parent_d[c*N_PINS + p] = core_any & pin_any[p];
        end
    end

    // Purpose: register the outputs, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) parent_q <= '0;
        else        parent_q <= parent_d;
    end

    assign parent_irq = parent_q;

endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Level-sensitive interrupt router. Routes enabled lines to core/pin
// parent outputs through per-line routing bytes behind a register port.
// Assumes a synchronous active-low reset and single-cycle access strobes.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_CORES = 4,
    parameter int unsigned N_PINS  = 4,
    localparam int unsigned RW         = N_CORES + N_PINS,
    localparam int unsigned N_PARENTS  = N_CORES * N_PINS,
    localparam int unsigned LINE_IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int unsigned CORE_IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_LINES-1:0]   irq_in,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [2:0]           bus_size,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [N_PARENTS-1:0] parent_irq
);

    acc_kind_e                  kind;
    logic [LINE_IDX_W-1:0]      line_idx;
    logic [CORE_IDX_W-1:0]      core_idx;
    logic [N_LINES-1:0]         enable;
    logic [N_LINES*RW-1:0]      route_flat;
    logic [N_LINES-1:0]         masked;
    logic [N_CORES*N_LINES-1:0] core_status;
    logic [N_PINS-1:0]          pin_any;

    irq_access_decode #(.N_LINES(N_LINES), .N_CORES(N_CORES)) u_decode (
        .addr     (bus_addr),
        .size     (bus_size),
        .kind     (kind),
        .line_idx (line_idx),
        .core_idx (core_idx)
    );

    irq_regfile #(.N_LINES(N_LINES), .N_CORES(N_CORES), .N_PINS(N_PINS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (bus_valid),
        .acc_write   (bus_write),
        .kind        (kind),
        .line_idx    (line_idx),
        .core_idx    (core_idx),
        .wdata       (bus_wdata),
        .masked      (masked),
        .core_status (core_status),
        .enable      (enable),
        .route_flat  (route_flat),
        .rdata       (bus_rdata)
    );

    irq_route_matrix #(.N_LINES(N_LINES), .N_CORES(N_CORES), .N_PINS(N_PINS)) u_matrix (
        .irq_in      (irq_in),
        .enable      (enable),
        .route_flat  (route_flat),
        .masked      (masked),
        .core_status (core_status),
        .pin_any     (pin_any)
    );

    irq_parent_drive #(.N_LINES(N_LINES), .N_CORES(N_CORES), .N_PINS(N_PINS)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_status (core_status),
        .pin_any     (pin_any),
        .parent_irq  (parent_irq)
    );

    // R7: with nothing pending at the last edge, every output is low now.
    a_r7_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(masked) == '0) |-> (parent_irq == '0));

    // R6: each raised output had both its core gate and its pin gate.
    for (genvar c = 0; c < int'(N_CORES); c++) begin : g_chk_core
        for (genvar p = 0; p < int'(N_PINS); p++) begin : g_chk_pin
            a_r6_core_gate: assert property (@(posedge clk) disable iff (!rst_n)
                parent_irq[c*N_PINS + p] |-> $past(|core_status[c*N_LINES +: N_LINES]));
            a_r6_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
                parent_irq[c*N_PINS + p] |-> $past(pin_any[p]));
        end
    end

endmodule

// File: tb/irq_router_test.sv
// Bench for irq_router: a vector table of line patterns under a fixed
// routing setup, then directed cases for reset and access corner cases.
module irq_router_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic        bus_valid;
    logic        bus_write;
    logic [2:0]  bus_size;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] parent_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  rt [32];
    logic [31:0] en_model;
    logic [31:0] rd;

    localparam logic [31:0] EN_MASK = 32'h00FF_F0FF;
    localparam int NVEC = 8;
    localparam logic [31:0] PATTERNS [NVEC] = '{
        32'h0000_0000,  // nothing pending
        32'h0000_0001,  // single line, core0 pin0
        32'h0000_0012,  // lines 1 and 4: cross product
        32'h0000_0200,  // disabled line only
        32'h0000_0040,  // pin-only line, no core
        32'h0000_0020,  // line routed everywhere
        32'hFFFF_FFFF,  // all lines
        32'hA5A5_A5A5   // checkerboard
    };

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .parent_irq(parent_irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge with the write applied.
    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d, input logic [2:0] s);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = s;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, input logic [2:0] s, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = s;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    function automatic logic [31:0] model_core(input logic [31:0] m, input int c);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) r[i] = m[i] & rt[i][c];
        return r;
    endfunction

    function automatic logic [15:0] model_parent(input logic [31:0] m);
        logic [15:0] r = '0;
        logic [3:0]  pin = '0;
        for (int i = 0; i < 32; i++)
            for (int p = 0; p < 4; p++) pin[p] = pin[p] | (m[i] & rt[i][4+p]);
        for (int c = 0; c < 4; c++)
            for (int p = 0; p < 4; p++)
                r[c*4+p] = (model_core(m, c) != 0) && pin[p];
        return r;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_size = 3'd4; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state with every line high.
        irq_in = '1;
        settle();
        check("R1", "parent after reset", {16'h0, parent_irq}, 32'h0);
        bus_rd(7'h24, 3'd4, rd); check("R1", "enable after reset", rd, 32'h0);
        bus_rd(7'h07, 3'd1, rd); check("R1", "route 7 after reset", rd, 32'h0);
        bus_rd(7'h20, 3'd4, rd); check("R1", "status after reset", rd, 32'h0);
        irq_in = '0;

        // R3: set and clear accumulate into the mask.
        bus_wr(7'h28, 32'h0000_00F0, 3'd4);
        bus_wr(7'h28, 32'h0000_0F00, 3'd4);
        bus_rd(7'h24, 3'd4, rd); check("R3", "mask after two sets", rd, 32'h0000_0FF0);
        bus_wr(7'h2C, 32'h0000_0030, 3'd4);
        bus_rd(7'h24, 3'd4, rd); check("R3", "mask after clear", rd, 32'h0000_0FC0);
        bus_wr(7'h2C, 32'hFFFF_FFFF, 3'd4);
        bus_rd(7'h24, 3'd4, rd); check("R3", "mask after full clear", rd, 32'h0);

        // R4: program routing bytes, bits 3:0 cores, bits 7:4 pins.
        for (int i = 0; i < 32; i++) begin
            if (i == 5)      rt[i] = 8'hFF;
            else if (i == 6) rt[i] = 8'h30;
            else             rt[i] = {4'(1 << ((i >> 2) & 3)), 4'(1 << (i & 3))};
            bus_wr(7'(i), {24'h0, rt[i]}, 3'd1);
        end
        bus_rd(7'h05, 3'd1, rd); check("R4", "route 5 readback", rd, 32'h0000_00FF);
        bus_rd(7'h1F, 3'd1, rd); check("R4", "route 31 readback", rd, {24'h0, rt[31]});
        bus_rd(7'h01, 3'd1, rd); check("R4", "route 1 readback", rd, 32'h0000_0012);

        bus_wr(7'h28, EN_MASK, 3'd4);
        en_model = EN_MASK;

        // R2 R5 R6: walk the pattern table.
        for (int k = 0; k < NVEC; k++) begin
            irq_in = PATTERNS[k];
            settle();
            check("R6", $sformatf("parent vec %0d", k), {16'h0, parent_irq},
                  {16'h0, model_parent(PATTERNS[k] & en_model)});
            bus_rd(7'h20, 3'd4, rd);
            check("R2", $sformatf("status vec %0d", k), rd, PATTERNS[k] & en_model);
            for (int c = 0; c < 4; c++) begin
                bus_rd(7'(8'h40 + 8 * c), 3'd4, rd);
                check("R5", $sformatf("core %0d vec %0d", c, k), rd,
                      model_core(PATTERNS[k] & en_model, c));
            end
        end

        // R6: explicit cross-product value for lines 1 and 4.
        irq_in = 32'h0000_0012;
        settle();
        check("R6", "cross product pairs", {16'h0, parent_irq}, 32'h0000_0033);

        // R7: dropping the line drops the outputs at the next edge.
        irq_in = 32'h0000_0001;
        settle();
        check("R7", "line high", {16'h0, parent_irq}, 32'h0000_0001);
        irq_in = '0;
        settle();
        check("R7", "line dropped", {16'h0, parent_irq}, 32'h0);
        irq_in = 32'h0000_0001;
        settle();
        bus_wr(7'h2C, 32'h0000_0001, 3'd4);
        settle();
        check("R7", "enable dropped", {16'h0, parent_irq}, 32'h0);
        bus_wr(7'h28, 32'h0000_0001, 3'd4);

        // R8: malformed accesses.
        bus_wr(7'h28, 32'hFFFF_FFFF, 3'd1);
        bus_rd(7'h24, 3'd4, rd); check("R8", "byte write at set offset", rd, EN_MASK);
        bus_wr(7'h2D, 32'hFFFF_FFFF, 3'd4);
        bus_rd(7'h24, 3'd4, rd); check("R8", "misaligned clear", rd, EN_MASK);
        bus_wr(7'h2C, 32'hFFFF_FFFF, 3'd2);
        bus_rd(7'h24, 3'd4, rd); check("R8", "half-word clear", rd, EN_MASK);
        bus_wr(7'h04, 32'h0000_0000, 3'd4);
        bus_rd(7'h04, 3'd1, rd); check("R8", "word write into routes", rd, {24'h0, rt[4]});
        bus_rd(7'h20, 3'd2, rd); check("R8", "half-word status read", rd, 32'h0);
        bus_rd(7'h00, 3'd4, rd); check("R8", "word read of routes", rd, 32'h0);
        bus_rd(7'h22, 3'd4, rd); check("R8", "misaligned status read", rd, 32'h0);

        // R9: unmapped reads, read-only writes.
        bus_wr(7'h24, 32'h0000_0000, 3'd4);
        bus_wr(7'h20, 32'h0000_0000, 3'd4);
        bus_wr(7'h30, 32'hFFFF_FFFF, 3'd4);
        bus_rd(7'h24, 3'd4, rd); check("R9", "enable after ro writes", rd, EN_MASK);
        bus_rd(7'h28, 3'd4, rd); check("R9", "read of set offset", rd, 32'h0);
        bus_rd(7'h2C, 3'd4, rd); check("R9", "read of clear offset", rd, 32'h0);
        bus_rd(7'h44, 3'd4, rd); check("R9", "read gap 0x44", rd, 32'h0);
        bus_rd(7'h60, 3'd4, rd); check("R9", "read 0x60", rd, 32'h0);
        bus_rd(7'h68, 3'd4, rd); check("R9", "read past window", rd, 32'h0);

        // R5: a write to a core word has no lasting effect.
        irq_in = 32'h0000_0011;
        bus_wr(7'h40, 32'hFFFF_FFFF, 3'd4);
        bus_rd(7'h40, 3'd4, rd);
        check("R5", "core0 after write", rd, model_core(32'h0000_0011, 0));

        // R1: reset in mid-run with lines active.
        irq_in = '1;
        rst_n = 1'b0;
        settle();
        rst_n = 1'b1;
        settle();
        check("R1", "parent after mid reset", {16'h0, parent_irq}, 32'h0);
        bus_rd(7'h24, 3'd4, rd); check("R1", "enable after mid reset", rd, 32'h0);
        bus_rd(7'h05, 3'd1, rd); check("R1", "route after mid reset", rd, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule